// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing of a video display. It runs a pixel counter and a line counter. From them it derives horizontal and vertical sync, a display-active flag, and a one-cycle prefetch strobe. The strobe fires a set number of pixels before the end of each line, so that a fetch engine can start loading the next line early. The block also holds a pan origin that a frame-buffer fetch unit uses as the top-left coordinate of the visible window.

Software sets it up through a simple write port. Every limit register holds the last count value of its interval, not a length. For example, an 800-pixel active width is programmed as 799. The horizontal sync start is programmed as active width plus front porch minus one. To reprogram a mode, software first clears both control bits, then writes the limits, and then sets the control bits again.

Top module: `vtg_top`

## Requirements
- R1: After reset both counters read 0, active, hsync, vsync and prefetch are low, the control bits are clear and the pan outputs are 0.
- R2: While enabled, the pixel counter counts up by one each cycle. It goes to 0 in the cycle after it equals the horizontal total register. On that wrap the line counter advances, and it goes to 0 after equalling the vertical total register.
- R3: While control bit 0 (enable) is clear, both counters are forced to 0 and held there.
- R4: Active is high only when both control bits are set, the pixel count is at or below the horizontal display register, and the line count is at or below the vertical display register.
- R5: Hsync is high when the pixel count is strictly greater than the hsync start register and at or below the hsync end register.
- R6: Vsync is high when the line count is strictly greater than the vsync start register and at or below the vsync end register.
- R7: Prefetch is high for exactly the cycles in which the pixel count equals the short-line register while both control bits are set. Software programs this register as total minus prefetch minus one.
- R8: The register map is: 0 control (bit 0 enable, bit 1 refresh), 1 horizontal total, 2 horizontal display, 3 hsync start, 4 hsync end, 5 vertical total, 6 vertical display, 7 vsync start, 8 vsync end, 9 short-line, 10 pan. A write to registers 1 to 9 is ignored while either control bit is set.
- R9: The pan register takes the horizontal offset from data bits 31:16, with bits 18:16 forced to 0 so the offset is a multiple of 8. It takes the vertical offset from bits 15:0. The pan register accepts writes at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Register index |
| wr_data_i | input | 32 | Write data |
| pix_cnt_o | output | CW | Pixel counter |
| line_cnt_o | output | CW | Line counter |
| active_o | output | 1 | Display-active flag |
| hsync_o | output | 1 | Raw horizontal sync |
| vsync_o | output | 1 | Raw vertical sync |
| prefetch_o | output | 1 | Early-line prefetch strobe |
| pan_x_o | output | 16 | Horizontal pan origin |
| pan_y_o | output | 16 | Vertical pan origin |

## Verification
Some properties are checked on every cycle. The counters step by one or wrap to zero at the total. Both counters sit at zero while disabled. Active never appears outside the display limits. Prefetch only appears at the short-line count. The limit registers do not change while the generator is running, and the pan offset stays 8-aligned.

Other behaviour can only be shown by the bench scenarios. These are the exact sync windows over several whole frames of a small mode, the loss of active and prefetch when only refresh is cleared, and the way a limit written during operation is rejected. Correct placement of the pan fields is likewise shown only by the bench.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int NLIM = 9;
  typedef enum logic [3:0] {
    REG_CTRL  = 4'd0,
    REG_HTOT  = 4'd1,
    REG_HDISP = 4'd2,
    REG_HSS   = 4'd3,
    REG_HSE   = 4'd4,
    REG_VTOT  = 4'd5,
    REG_VDISP = 4'd6,
    REG_VSS   = 4'd7,
    REG_VSE   = 4'd8,
    REG_SHORT = 4'd9,
    REG_PAN   = 4'd10
  } reg_e;
  // limit array index = register index - 1
  localparam int L_HTOT  = 0;
  localparam int L_HDISP = 1;
  localparam int L_HSS   = 2;
  localparam int L_HSE   = 3;
  localparam int L_VTOT  = 4;
  localparam int L_VDISP = 5;
  localparam int L_VSS   = 6;
  localparam int L_VSE   = 7;
  localparam int L_SHORT = 8;
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
#(
  parameter int CW = 12,
  parameter int AW = 4,
  parameter logic [NLIM*CW-1:0] LIM_RST = '0
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [AW-1:0]             wr_addr_i,
  input  logic [31:0]               wr_data_i,
  output logic [1:0]                ctrl_o,
  output logic [NLIM-1:0][CW-1:0]   lim_o,
  output logic [15:0]               pan_x_o,
  output logic [15:0]               pan_y_o
);
  logic [1:0] ctrl_q;
  logic [NLIM-1:0][CW-1:0] lim_q;
  logic [15:0] pan_x_q, pan_y_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      pan_x_q <= '0;
      pan_y_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == AW'(REG_CTRL)) ctrl_q <= wr_data_i[1:0];
      if (wr_addr_i == AW'(REG_PAN)) begin
        pan_x_q <= {wr_data_i[31:19], 3'b000};
        pan_y_q <= wr_data_i[15:0];
      end
    end
  end

  // limits only accept writes while the generator is fully stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q <= LIM_RST;
    end else if (wr_en_i && ctrl_q == 2'b00) begin
      for (int i = 0; i < NLIM; i++)
        if (wr_addr_i == AW'(i + 1)) lim_q[i] <= wr_data_i[CW-1:0];
    end
  end

  assign ctrl_o  = ctrl_q;
  assign lim_o   = lim_q;
  assign pan_x_o = pan_x_q;
  assign pan_y_o = pan_y_q;
endmodule

// File: rtl/vtg_counter.sv
module vtg_counter #(
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          step_i,
  input  logic [CW-1:0] last_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q;

  assign wrap_o = step_i && (cnt_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/vtg_window.sv
module vtg_window #(
  parameter int CW = 12
) (
  input  logic [CW-1:0] pos_i,
  input  logic [CW-1:0] start_i,
  input  logic [CW-1:0] stop_i,
  output logic          in_o
);
  // open at start, closed at stop
  assign in_o = (pos_i > start_i) && (pos_i <= stop_i);
endmodule

// File: rtl/vtg_top.sv
module vtg_top
  import vtg_pkg::*;
#(
  parameter int CW     = 12,
  parameter int AW     = 4,
  parameter int H_ACT  = 1280,
  parameter int H_FP   = 48,
  parameter int H_SYNC = 112,
  parameter int H_BP   = 248,
  parameter int V_ACT  = 1024,
  parameter int V_FP   = 1,
  parameter int V_SYNC = 3,
  parameter int V_BP   = 38,
  parameter int PREF   = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [31:0]   wr_data_i,
  output logic [CW-1:0] pix_cnt_o,
  output logic [CW-1:0] line_cnt_o,
  output logic          active_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          prefetch_o,
  output logic [15:0]   pan_x_o,
  output logic [15:0]   pan_y_o
);
  localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int PF_C  = (PREF >= H_TOT) ? H_TOT - 1 : PREF;
  localparam logic [NLIM*CW-1:0] LIM_RST = {
    CW'(H_TOT - PF_C - 1),
    CW'(V_ACT + V_FP + V_SYNC - 1), CW'(V_ACT + V_FP - 1),
    CW'(V_ACT - 1), CW'(V_TOT - 1),
    CW'(H_ACT + H_FP + H_SYNC - 1), CW'(H_ACT + H_FP - 1),
    CW'(H_ACT - 1), CW'(H_TOT - 1)
  };

  logic [1:0] ctrl;
  logic [NLIM-1:0][CW-1:0] lim;
  logic en, refresh, pix_wrap, line_wrap, hs_in, vs_in;

  vtg_regs #(.CW(CW), .AW(AW), .LIM_RST(LIM_RST)) regs_i (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .ctrl_o(ctrl), .lim_o(lim), .pan_x_o, .pan_y_o
  );

  assign en      = ctrl[0];
  assign refresh = ctrl[1];

  vtg_counter #(.CW(CW)) hcnt_i (
    .clk_i, .rst_ni, .en_i(en), .step_i(1'b1), .last_i(lim[L_HTOT]),
    .cnt_o(pix_cnt_o), .wrap_o(pix_wrap)
  );

  vtg_counter #(.CW(CW)) vcnt_i (
    .clk_i, .rst_ni, .en_i(en), .step_i(pix_wrap), .last_i(lim[L_VTOT]),
    .cnt_o(line_cnt_o), .wrap_o(line_wrap)
  );

  vtg_window #(.CW(CW)) hwin_i (
    .pos_i(pix_cnt_o), .start_i(lim[L_HSS]), .stop_i(lim[L_HSE]), .in_o(hs_in)
  );

  vtg_window #(.CW(CW)) vwin_i (
    .pos_i(line_cnt_o), .start_i(lim[L_VSS]), .stop_i(lim[L_VSE]), .in_o(vs_in)
  );

  assign hsync_o    = hs_in;
  assign vsync_o    = vs_in;
  assign active_o   = en && refresh && (pix_cnt_o <= lim[L_HDISP]) &&
                      (line_cnt_o <= lim[L_VDISP]);
  assign prefetch_o = en && refresh && (pix_cnt_o == lim[L_SHORT]);
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker
  import vtg_pkg::*;
#(
  parameter int CW = 12
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [1:0]              ctrl,
  input logic [NLIM-1:0][CW-1:0] lim,
  input logic [CW-1:0]           pix_cnt_o,
  input logic [CW-1:0]           line_cnt_o,
  input logic                    active_o,
  input logic                    prefetch_o,
  input logic [15:0]             pan_x_o
);
  // R3
  disabled_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl[0] |=> (pix_cnt_o == '0 && line_cnt_o == '0));
  // R2
  pix_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl[0] && pix_cnt_o != lim[L_HTOT] && $stable(ctrl)) |=>
      pix_cnt_o == $past(pix_cnt_o) + 1'b1);
  // R2
  pix_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl[0] && pix_cnt_o == lim[L_HTOT]) |=> pix_cnt_o == '0);
  // R4
  active_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> (pix_cnt_o <= lim[L_HDISP] && line_cnt_o <= lim[L_VDISP]));
  // R7
  prefetch_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prefetch_o |-> (pix_cnt_o == lim[L_SHORT] && ctrl == 2'b11));
  // R8
  lim_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl != 2'b00 |=> $stable(lim));
  // R9
  pan_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pan_x_o[2:0] == 3'b000);
endmodule

bind vtg_top vtg_checker #(.CW(CW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctrl(ctrl), .lim(lim),
  .pix_cnt_o(pix_cnt_o), .line_cnt_o(line_cnt_o), .active_o(active_o),
  .prefetch_o(prefetch_o), .pan_x_o(pan_x_o)
);

// File: tb/vtg_top_tb_top.sv
module vtg_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;
  localparam int AW = 4;

  logic clk = 0, rst_ni = 0, wr_en = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [CW-1:0] pix, line;
  logic active, hsync, vsync, prefetch;
  logic [15:0] pan_x, pan_y;

  int tests = 0, fails = 0;

  // bench model state
  int m_pix = 0, m_line = 0;
  bit m_en = 0, m_ref = 0;
  int m_lim [9];

  always #(CLK_PERIOD/2) clk = ~clk;

  vtg_top #(.CW(CW), .AW(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pix_cnt_o(pix), .line_cnt_o(line),
    .active_o(active), .hsync_o(hsync), .vsync_o(vsync),
    .prefetch_o(prefetch), .pan_x_o(pan_x), .pan_y_o(pan_y)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // advance model across one rising edge using pre-edge control
  task automatic step_model();
    if (!m_en) begin
      m_pix = 0; m_line = 0;
    end else if (m_pix == m_lim[0]) begin
      m_pix = 0;
      m_line = (m_line == m_lim[4]) ? 0 : m_line + 1;
    end else m_pix++;
  endtask

  // called at negedge; returns at next negedge
  task automatic wr(input int a, input logic [31:0] d);
    bit idle;
    wr_en = 1; wr_addr = AW'(a); wr_data = d;
    idle = !m_en && !m_ref;
    @(posedge clk);
    step_model();
    if (a == 0) begin m_en = d[0]; m_ref = d[1]; end
    if (a >= 1 && a <= 9 && idle) m_lim[a-1] = int'(d[CW-1:0]);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      bit e_act, e_hs, e_vs, e_pf;
      e_act = m_en && m_ref && m_pix <= m_lim[1] && m_line <= m_lim[5];
      e_hs  = m_pix > m_lim[2] && m_pix <= m_lim[3];
      e_vs  = m_line > m_lim[6] && m_line <= m_lim[7];
      e_pf  = m_en && m_ref && m_pix == m_lim[8];
      chk("R2 pix", int'(pix), m_pix);
      chk("R2 line", int'(line), m_line);
      chk("R4 active", int'(active), int'(e_act));
      chk("R5 hsync", int'(hsync), int'(e_hs));
      chk("R6 vsync", int'(vsync), int'(e_vs));
      chk("R7 prefetch", int'(prefetch), int'(e_pf));
      @(posedge clk);
      step_model();
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1 pix", int'(pix), 0);
    chk("R1 line", int'(line), 0);
    chk("R1 outs", int'({active, hsync, vsync, prefetch}), 0);
    chk("R1 pan", int'({pan_x, pan_y}), 0);
  endtask

  // small mode: 8 act, fp 2, sync 3, bp 4 (total 17); 4 lines, fp 1, sync 2, bp 2 (total 9)
  task automatic t_program();
    wr(1, 16); wr(2, 7); wr(3, 9); wr(4, 12);
    wr(5, 8);  wr(6, 3); wr(7, 4); wr(8, 6);
    wr(9, 12);
    run(3);  // R3: still disabled, counters held at 0
    wr(0, 3);
    run(17 * 9 * 2 + 5);
  endtask

  task automatic t_locked_write();
    // R8: horizontal total write while running is ignored
    wr(1, 5);
    run(17 * 3);
  endtask

  task automatic t_refresh_off();
    // R4 R7: refresh cleared, syncs still run
    wr(0, 1);
    run(17 * 9);
    wr(0, 3);
    run(20);
  endtask

  task automatic t_pan();
    wr(10, 32'h0013_0022);
    chk("R9 pan_x", int'(pan_x), 16'h0010);
    chk("R9 pan_y", int'(pan_y), 16'h0022);
    wr(10, 32'hFFFF_0001);
    chk("R9 pan_x hi", int'(pan_x), 16'hFFF8);
    chk("R9 pan_y lo", int'(pan_y), 1);
    run(4);
  endtask

  task automatic t_disable();
    // R3 then R8: reprogram once stopped
    wr(0, 0);
    run(10);
    wr(1, 11);
    wr(0, 3);
    run(12 * 9 + 6);
  endtask

  initial begin
    m_lim[0] = 1687; m_lim[1] = 1279; m_lim[2] = 1327; m_lim[3] = 1439;
    m_lim[4] = 1065; m_lim[5] = 1023; m_lim[6] = 1024; m_lim[7] = 1027;
    m_lim[8] = 1623;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    rst_ni = 1;
    t_reset();
    t_program();
    t_locked_write();
    t_refresh_off();
    t_pan();
    t_disable();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule